// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a three-wire link to a 14-bit successive-approximation converter. A single-cycle `start` pulse makes it pull the chip select low and toggle a serial clock that it derives from the system clock. Each half period of that clock lasts a programmable number of system cycles. The converter samples its input when chip select falls and then shifts out a 16-bit frame: two zero bits followed by the 14 result bits, most significant first. The controller always runs the complete frame. It never releases chip select early, because doing so would abort the conversion.

A mode input selects which serial clock edge the controller uses to sample the data line. On falling edges it collects all 16 bits. On rising edges the first zero cannot be seen, so it collects the second zero and the 14 data bits on rising edges 1 to 15. At the end of the frame the 14-bit value appears together with a one-cycle `done` pulse and a flag that reports a nonzero leading bit. Chip select then stays high for a programmable quiet time, and `busy` stays high until that time has run out.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While `rst_n` is low, `cs_n` and `sclk` are 1, and `busy`, `done`, `fmt_err` and `result` are 0.
- R2: When `start` is sampled in idle, `cs_n` goes low on that edge and `sclk` stays high. `sclk` then toggles every H system cycles, where H is `half_div` or 2 if `half_div` is below 2. This gives 16 falling and 16 rising edges, and the first edge is a falling one. `cs_n` returns high and `done` pulses 33·H cycles after the start edge.
- R3: With `edge_sel`=0, `sdata` is sampled at each `sclk` falling edge. Bit 1 of the frame is the first zero and bit 2 is the second zero. Bits 3 to 16 form `result[13:0]`, MSB first.
- R4: With `edge_sel`=1, `sdata` is sampled at rising edges 1 to 15. Edge 1 carries the second zero and edges 2 to 15 carry `result[13:0]`, MSB first. The first zero bit is never sampled.
- R5: `fmt_err` is set with `done` when a sampled zero-position bit is 1. With `edge_sel`=0 both zero positions are checked. With `edge_sel`=1 only the second is checked.
- R6: `done` lasts exactly one cycle. `result` and `fmt_err` keep their values until the next `done`.
- R7: `busy` is 1 from the cycle after the accepted start until max(Q,1) cycles after the `done` cycle, where Q is `quiet_cyc`. A `start` received while `busy` is 1 has no effect.
- R8: `edge_sel`, `half_div` and `quiet_cyc` are taken only at the accepted start. Changes during a frame do not alter its timing, its capture mode or its quiet time.
- R9: `cs_n` rises only after all 16 falling `sclk` edges of the frame. `sclk` is 1 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request for a frame |
| edge_sel | input | 1 | 0: sample on SCLK falling edges, 1: sample on rising edges |
| half_div | input | DIV_W | SCLK half period in system cycles (minimum 2) |
| quiet_cyc | input | QUIET_W | Minimum chip-select high time after a frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or quiet time in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| fmt_err | output | 1 | A leading-zero position carried a 1 |
| result | output | 14 | Received conversion value |

## Verification
The bench uses the default widths of 8 bits for the divider and the quiet counter. It runs frames with half periods of 2, 3, 4 and 5 cycles. It also uses the values 0 and 1, which must be clamped to 2, so it can confirm that the frame length scales with H. Quiet values of 0, 1 and several larger ones show the max(Q,1) floor and an exact busy length. A converter model in the bench answers the chip select and clock lines. This lets it place a 1 in either zero position and show the different error checking in the two modes.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_ZEROS = 2;
  localparam int RES_BITS   = FRAME_BITS - LEAD_ZEROS;
  localparam int SCLK_EDGES = 2 * FRAME_BITS;
  localparam int MIN_HALF   = 2;
  localparam int ECNT_W     = $clog2(SCLK_EDGES + 2);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_QUIET = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/adc_rd_timer.sv
// Half-period timer and SCLK edge sequencer.
module adc_rd_timer
  import adc_rd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [DIV_W-1:0]  half_div,
  output logic              tick,
  output logic [ECNT_W-1:0] ecnt,
  output logic              sclk
);
  localparam logic [DIV_W-1:0]  HALF_MIN = DIV_W'(MIN_HALF);
  localparam logic [ECNT_W-1:0] EDGE_LIM = ECNT_W'(SCLK_EDGES);

  logic [DIV_W-1:0]  hd_q, hd_d;
  logic [DIV_W-1:0]  hcnt_q, hcnt_d;
  logic [ECNT_W-1:0] ecnt_q, ecnt_d;
  logic              sclk_q, sclk_d;

  assign tick = run && (hcnt_q == hd_q - 1'b1);
  assign ecnt = ecnt_q;
  assign sclk = sclk_q;

  always_comb begin
    hd_d   = hd_q;
    hcnt_d = hcnt_q;
    ecnt_d = ecnt_q;
    sclk_d = sclk_q;
    if (clear) begin
      hd_d   = (half_div < HALF_MIN) ? HALF_MIN : half_div;
      hcnt_d = '0;
      ecnt_d = '0;
      sclk_d = 1'b1;
    end else if (run) begin
      if (tick) begin
        hcnt_d = '0;
        if (ecnt_q <= EDGE_LIM) ecnt_d = ecnt_q + 1'b1;
        if (ecnt_q < EDGE_LIM)  sclk_d = ~sclk_q;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end else begin
      sclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q   <= HALF_MIN;
      hcnt_q <= '0;
      ecnt_q <= '0;
      sclk_q <= 1'b1;
    end else begin
      hd_q   <= hd_d;
      hcnt_q <= hcnt_d;
      ecnt_q <= ecnt_d;
      sclk_q <= sclk_d;
    end
  end

  // R2: the half-period counter never passes the latched divider
  a_r2_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt_q < hd_q));
  // R2: the divider in use is never below the minimum
  a_r2_half_min: assert property (@(posedge clk) disable iff (!rst_n)
    hd_q >= HALF_MIN);
endmodule

// File: rtl/adc_rd_capture.sv
// Frame shift register, result and format-flag registers.
module adc_rd_capture
  import adc_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                cap_en,
  input  logic                bit_in,
  input  logic                load,
  input  logic                mode_fall,
  output logic [RES_BITS-1:0] result,
  output logic                fmt_err
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [RES_BITS-1:0]   res_q, res_d;
  logic                  err_q, err_d;
  logic                  lead_bad;

  // Falling mode holds both zeros above the data; rising mode only the second.
  always_comb begin
    lead_bad = 1'b0;
    for (int i = RES_BITS; i < FRAME_BITS; i++) begin
      if (mode_fall || i == RES_BITS) lead_bad = lead_bad | sh_q[i];
    end
  end

  always_comb begin
    sh_d  = sh_q;
    res_d = res_q;
    err_d = err_q;
    if (clear)       sh_d = '0;
    else if (cap_en) sh_d = {sh_q[FRAME_BITS-2:0], bit_in};
    if (load) begin
      res_d = sh_q[RES_BITS-1:0];
      err_d = lead_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      err_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      res_q <= res_d;
      err_q <= err_d;
    end
  end

  assign result  = res_q;
  assign fmt_err = err_q;

  // R6: result and flag only move on a load
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(res_q) && $stable(err_q)));
  // R3: a capture and a frame restart never coincide
  a_r3_no_cap_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && cap_en));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                edge_sel,
  input  logic [DIV_W-1:0]    half_div,
  input  logic [QUIET_W-1:0]  quiet_cyc,
  input  logic                sdata,
  output logic                cs_n,
  output logic                sclk,
  output logic                busy,
  output logic                done,
  output logic                fmt_err,
  output logic [RES_BITS-1:0] result
);
  localparam int QC_W = QUIET_W + 1;
  localparam logic [ECNT_W-1:0] EDGE_LIM = ECNT_W'(SCLK_EDGES);
  localparam logic [ECNT_W-1:0] RISE_END = ECNT_W'(SCLK_EDGES - 3);

  ctrl_state_e       state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic              mode_q, mode_d;      // 1: rising-edge capture
  logic [QUIET_W-1:0] q_q, q_d;
  logic [QC_W-1:0]   qcnt_q, qcnt_d;
  logic [QC_W-1:0]   q_lim;
  logic              accept, run, tick, last, cap_en, sclk_w;
  logic [ECNT_W-1:0] ecnt;

  assign accept = (state_q == ST_IDLE) && start;
  assign run    = (state_q == ST_XFER);
  assign last   = tick && (ecnt == EDGE_LIM);
  assign q_lim  = (q_q == '0) ? QC_W'(1) : {1'b0, q_q};

  // Even edge index = falling edge, odd = rising edge.
  always_comb begin
    if (!mode_q) cap_en = tick && !ecnt[0] && (ecnt < EDGE_LIM);
    else         cap_en = tick &&  ecnt[0] && (ecnt <= RISE_END);
  end

  adc_rd_timer #(.DIV_W(DIV_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .run      (run),
    .half_div (half_div),
    .tick     (tick),
    .ecnt     (ecnt),
    .sclk     (sclk_w)
  );

  adc_rd_capture capture_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .cap_en    (cap_en),
    .bit_in    (sdata),
    .load      (last),
    .mode_fall (!mode_q),
    .result    (result),
    .fmt_err   (fmt_err)
  );

  always_comb begin
    state_d = state_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    mode_d  = mode_q;
    q_d     = q_q;
    qcnt_d  = qcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_XFER;
          cs_n_d  = 1'b0;
          mode_d  = edge_sel;
          q_d     = quiet_cyc;
        end
      end
      ST_XFER: begin
        qcnt_d = '0;
        if (last) begin
          state_d = ST_QUIET;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end
      end
      ST_QUIET: begin
        qcnt_d = qcnt_q + 1'b1;
        if (qcnt_q + 1'b1 >= q_lim) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
      q_q     <= '0;
      qcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      mode_q  <= mode_d;
      q_q     <= q_d;
      qcnt_q  <= qcnt_d;
    end
  end

  assign cs_n = cs_n_q;
  assign sclk = sclk_w;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // Checker support: falling SCLK edges seen while CS is low.
  logic       sclk_prev;
  logic [5:0] chk_falls;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      chk_falls <= '0;
    end else begin
      sclk_prev <= sclk_w;
      if (cs_n_q)                     chk_falls <= '0;
      else if (sclk_prev && !sclk_w)  chk_falls <= chk_falls + 1'b1;
    end
  end

  // R9: clock parked high whenever the converter is deselected
  a_r9_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_w);
  // R9: chip select released only after all sixteen falling edges
  a_r9_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (chk_falls == 6'd16 && done_q));
  // R6: done never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: a start while busy never opens a frame
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$fell(cs_n_q));
  // R7: busy drops only with chip select high
  a_r7_busy_end_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cs_n_q);
endmodule

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        edge_sel = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic [7:0]  quiet_cyc = 8'd0;
  logic        sdata = 1'b0;
  logic        cs_n, sclk, busy, done, fmt_err;
  logic [13:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  adc_rd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_sel(edge_sel),
    .half_div(half_div), .quiet_cyc(quiet_cyc), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done),
    .fmt_err(fmt_err), .result(result)
  );

  // Converter model: first bit on CS fall, next bit on each SCLK fall.
  logic [15:0] adc_word = 16'h0;
  int adc_idx = 0;
  int n_falls = 0;
  int n_rises = 0;
  always @(negedge cs_n) begin
    adc_idx = 0;
    sdata = adc_word[15];
  end
  always @(negedge sclk) if (!cs_n) begin
    n_falls++;
    adc_idx++;
    if (adc_idx < 16) sdata = adc_word[15 - adc_idx];
  end
  always @(posedge sclk) if (!cs_n) n_rises++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic test_reset();
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "cs_n/sclk in reset",
        {cs_n, sclk}, 2'b11);
    chk(busy == 0 && done == 0 && fmt_err == 0, "R1", "flags in reset",
        {busy, done, fmt_err}, 0);
    chk(result == 14'h0, "R1", "result in reset", result, 0);
  endtask

  // One complete frame; poke injects a start and setting changes mid-frame.
  task automatic run_frame(input bit mode, input int hd, input int q,
                           input bit z1, input bit z2, input logic [13:0] data,
                           input bit poke);
    int hde, n, m, qe;
    bit exp_err;
    hde = (hd < 2) ? 2 : hd;
    qe  = (q < 1) ? 1 : q;
    exp_err = mode ? z2 : (z1 | z2);
    adc_word = {z1, z2, data};
    n_falls = 0;
    n_rises = 0;
    @(negedge clk);
    edge_sel = mode;
    half_div = 8'(hd);
    quiet_cyc = 8'(q);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy && !cs_n && sclk, "R2", "frame opened, sclk high",
        {busy, cs_n, sclk}, 3'b101);
    while (!done && n < 5000) begin
      if (poke && n == 20) begin
        start = 1'b1;
        edge_sel = ~mode;
        half_div = 8'd7;
        quiet_cyc = 8'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 33 * hde + 1, "R2", "cycles start to done", n, 33 * hde + 1);
    chk(n_falls == 16 && n_rises == 16, "R9", "sclk edges in frame",
        n_falls * 256 + n_rises, 16 * 256 + 16);
    chk(cs_n == 1'b1, "R9", "cs_n high at done", cs_n, 1);
    chk(result == data, mode ? "R4" : "R3", "result", result, data);
    chk(fmt_err == exp_err, "R5", "fmt_err", fmt_err, exp_err);
    if (poke) chk(result == data, "R8", "mode kept despite change", result, data);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done one cycle", done, 0);
    m = 1;
    while (busy && m < 1000) begin
      @(negedge clk);
      m++;
    end
    chk(m == qe, "R7", "busy after done", m, qe);
    if (poke) chk(m == qe, "R8", "quiet time latched", m, qe);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && !busy, "R7", "no frame from ignored start",
        {cs_n, busy}, 2'b10);
    chk(result == data && fmt_err == exp_err, "R6", "outputs held",
        {fmt_err, result}, {exp_err, data});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(1'b0, 2, 3, 1'b0, 1'b0, 14'h2A5C, 1'b0);
    run_frame(1'b0, 5, 0, 1'b0, 1'b0, 14'h3FFF, 1'b0);
    run_frame(1'b1, 3, 4, 1'b1, 1'b0, 14'h1234, 1'b0);
    run_frame(1'b0, 2, 2, 1'b1, 1'b0, 14'h0001, 1'b0);
    run_frame(1'b1, 2, 2, 1'b0, 1'b1, 14'h2000, 1'b0);
    run_frame(1'b0, 0, 1, 1'b0, 1'b0, 14'h1555, 1'b0);
    run_frame(1'b1, 4, 6, 1'b0, 1'b0, 14'h0AB3, 1'b1);
    run_frame(1'b0, 1, 5, 1'b0, 1'b1, 14'h0000, 1'b1);
    finish_run();
  end
endmodule